// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash device. It watches single-cycle host write strobes, each carrying an address and a data byte. It accepts only command sequences that open with a two-write unlock prefix. From those sequences it enters program, chip-erase, sector-erase, identifier-read and erase-suspend modes. A separate single-cycle read strobe loads a registered read-data path. That path returns the addressed array byte, an identifier byte, or a status byte whose bits toggle while an embedded operation is under way.

Program and erase work goes out through a small array port. The block raises a one-cycle start with the operation type, the target address and data, and a one-bit-per-sector erase mask. It then waits for a one-cycle done pulse from the array. A level output holds the array paused while an erase is suspended. A ready output drops for as long as an operation is in flight.

Sectors are addressed by the top `SECT_W` bits of the address, so the defaults give sixteen sectors of 4096 locations.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command opens with data AAh written to the first unlock address, followed by data 55h written to the second unlock address. The addresses are 5555h and 2AAAh when `byte_sel` is 0, and AAAAh and 5555h when `byte_sel` is 1. Command bytes A0h, 80h and 90h, and the chip-erase byte 10h, must be written to the first unlock address.
- R2: A write that breaks the expected sequence returns the decoder to array mode and does not start a new sequence. This includes F0h in any position. In array mode and part-way through a sequence, a read returns `arr_rdata` on `rdata` in the cycle after `rd_en`.
- R3: After the unlock pair and A0h, the next write of any address and data produces `arr_start` high for exactly one cycle, in the cycle after that write. With it come `arr_op` = 0 (program), `arr_addr` = the written address and `arr_wdata` = the written data.
- R4: The chip-erase sequence is unlock, 80h, unlock, then 10h. It produces `arr_start` in the cycle after the 10h write, with `arr_op` = 1 (erase) and `arr_mask` all ones.
- R5: The sector-erase sequence is unlock, 80h, unlock, then 30h at any address. It selects the sector given by the address's top `SECT_W` bits and opens a window of `SE_WIN` cycles. Every 30h write on the `SE_WIN` clock edges that follow adds its sector to the mask. `arr_start` (erase, with the collected mask) appears `SE_WIN` cycles after the first 30h write.
- R6: `rdy` is 1 after reset. It goes to 0 in the cycle after the final write of a program or erase sequence, and returns to 1 in the cycle after `arr_done`. While busy, all writes are ignored except the suspend command described in R10.
- R7: The unlock pair followed by 90h enters identifier mode. In this mode a read at low-byte offset 0 returns 04h. Offset 1 (word) or 2 (byte) returns the device code, 58h by default. Offset 2 (word) or 4 (byte) returns 01h if the addressed sector's bit in `PROT_MASK` is set and 00h otherwise. Any other offset returns 00h. Any write leaves identifier mode for array mode.
- R8: While a program is busy, a read returns the complement of the programmed bit 7 in bit 7, a toggle bit in bit 6, and zeros elsewhere. The toggle bit is 0 on the first such read after reset and inverts after every status read.
- R9: While an erase is in its window or running, a read returns 0 in bit 7, the shared bit-6 toggle (inverting per read), and a second toggle in bit 2. The bit-2 toggle inverts only on reads from sectors in the erase mask. All other bits are 0.
- R10: B0h written while a sector erase runs sets `arr_suspend` and `rdy` to 1. During suspend, reads from sectors outside the mask return array data. Reads from masked sectors return bit 7 = 1, bit 6 held, and bit 2 toggling. A 30h write resumes, clearing `arr_suspend` and `rdy`. B0h during a chip erase is ignored.
- R11: When `arr_done` and a B0h write fall in the same cycle, the completion wins: `rdy` returns to 1, `arr_suspend` stays 0 and the decoder is in array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_sel | input | 1 | Selects byte-mode unlock addresses and identifier offsets |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| addr | input | ADDR_W | Host address for writes and reads |
| wdata | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe, one cycle per read |
| rdata | output | 8 | Registered read data |
| rdy | output | 1 | High when no program or erase is in flight |
| arr_start | output | 1 | One-cycle request to the array |
| arr_op | output | 1 | 0 = program, 1 = erase |
| arr_addr | output | ADDR_W | Program target address |
| arr_wdata | output | 8 | Program data |
| arr_mask | output | 2**SECT_W | Sectors to erase |
| arr_suspend | output | 1 | Holds the array's erase in pause |
| arr_done | input | 1 | One-cycle completion from the array |
| arr_rdata | input | 8 | Array content at `addr` |

## Verification
The one collision that matters is the array's done pulse landing in the same clock as an erase-suspend write. The two disagree about the next mode. The bench counts down its own fixed-latency array responder and issues the B0h write on the exact cycle the responder raises done. The per-cycle model then expects array mode, ready high and suspend low from the following cycle. Window-edge timing is exercised as well, by a second 30h write placed on the last cycle of the sector-collection window.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_UNL1,
    ST_UNL2,
    ST_PGM_DATA,
    ST_ERS1,
    ST_ERS2,
    ST_ERS3,
    ST_AUTOSEL,
    ST_PGM_BUSY,
    ST_ERS_WIN,
    ST_ERS_RUN,
    ST_ERS_SUSP
  } dec_state_e;

  typedef enum logic {
    OP_PROGRAM = 1'b0,
    OP_ERASE   = 1'b1
  } arr_op_e;

  localparam logic [7:0] CMD_KEY_A  = 8'hAA;
  localparam logic [7:0] CMD_KEY_B  = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;
  localparam logic [7:0] CMD_ESETUP = 8'h80;
  localparam logic [7:0] CMD_CHIP   = 8'h10;
  localparam logic [7:0] CMD_SECT   = 8'h30;
  localparam logic [7:0] CMD_SUSP   = 8'hB0;
  localparam logic [7:0] CMD_IDENT  = 8'h90;

  // status byte: bit7 polarity flag, bit6 global toggle, bit2 sector toggle
  function automatic logic [7:0] status_byte(input logic b7, input logic b6, input logic b2);
    return {b7, b6, 3'b000, b2, 2'b00};
  endfunction

  function automatic logic is_busy(input dec_state_e s);
    return (s == ST_PGM_BUSY) || (s == ST_ERS_WIN) || (s == ST_ERS_RUN);
  endfunction

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4,
  parameter int SE_WIN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 byte_sel,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  input  logic                 arr_done,
  output dec_state_e           st,
  output logic                 arr_start,
  output arr_op_e              arr_op,
  output logic [ADDR_W-1:0]    arr_addr,
  output logic [7:0]           arr_wdata,
  output logic [(1<<SECT_W)-1:0] arr_mask,
  output logic                 arr_suspend,
  output logic                 rdy
);

  localparam int NSECT = 1 << SECT_W;
  localparam int WIN_W = $clog2(SE_WIN + 1);

  function automatic logic [ADDR_W-1:0] key_addr_a(input logic bs);
    return bs ? ADDR_W'(16'hAAAA) : ADDR_W'(16'h5555);
  endfunction

  function automatic logic [ADDR_W-1:0] key_addr_b(input logic bs);
    return bs ? ADDR_W'(16'h5555) : ADDR_W'(16'h2AAA);
  endfunction

  function automatic logic [NSECT-1:0] sector_bit(input logic [ADDR_W-1:0] a);
    logic [NSECT-1:0] v;
    v = '0;
    v[a[ADDR_W-1 -: SECT_W]] = 1'b1;
    return v;
  endfunction

  dec_state_e          st_q, st_n;
  logic                start_q, start_n;
  arr_op_e             op_q, op_n;
  logic [ADDR_W-1:0]   addr_q, addr_n;
  logic [7:0]          data_q, data_n;
  logic [NSECT-1:0]    mask_q, mask_n;
  logic [WIN_W-1:0]    win_q, win_n;
  logic                chip_q, chip_n;

  // named events for the checks
  logic at_key_a, at_key_b;
  logic key_a_hit, key_b_hit;
  logic cmd_done_evt;
  logic susp_req;
  logic win_last;

  assign at_key_a     = (addr == key_addr_a(byte_sel));
  assign at_key_b     = (addr == key_addr_b(byte_sel));
  assign key_a_hit    = wr_en && at_key_a && (wdata == CMD_KEY_A);
  assign key_b_hit    = wr_en && at_key_b && (wdata == CMD_KEY_B);
  assign cmd_done_evt = arr_done && ((st_q == ST_PGM_BUSY) || (st_q == ST_ERS_RUN));
  assign susp_req     = wr_en && (wdata == CMD_SUSP) && (st_q == ST_ERS_RUN) && !chip_q;
  assign win_last     = (st_q == ST_ERS_WIN) && (win_q == WIN_W'(SE_WIN - 1));

  always_comb begin
    st_n    = st_q;
    start_n = 1'b0;
    op_n    = op_q;
    addr_n  = addr_q;
    data_n  = data_q;
    mask_n  = mask_q;
    win_n   = win_q;
    chip_n  = chip_q;
    unique case (st_q)
      ST_ARRAY: if (wr_en) st_n = key_a_hit ? ST_UNL1 : ST_ARRAY;
      ST_UNL1:  if (wr_en) st_n = key_b_hit ? ST_UNL2 : ST_ARRAY;
      ST_UNL2: begin
        if (wr_en) begin
          st_n = ST_ARRAY;
          if (at_key_a) begin
            case (wdata)
              CMD_PROG:   st_n = ST_PGM_DATA;
              CMD_ESETUP: st_n = ST_ERS1;
              CMD_IDENT:  st_n = ST_AUTOSEL;
              default:    st_n = ST_ARRAY;
            endcase
          end
        end
      end
      ST_PGM_DATA: begin
        if (wr_en) begin
          st_n    = ST_PGM_BUSY;
          start_n = 1'b1;
          op_n    = OP_PROGRAM;
          addr_n  = addr;
          data_n  = wdata;
        end
      end
      ST_ERS1: if (wr_en) st_n = key_a_hit ? ST_ERS2 : ST_ARRAY;
      ST_ERS2: if (wr_en) st_n = key_b_hit ? ST_ERS3 : ST_ARRAY;
      ST_ERS3: begin
        if (wr_en) begin
          if (at_key_a && wdata == CMD_CHIP) begin
            st_n    = ST_ERS_RUN;
            start_n = 1'b1;
            op_n    = OP_ERASE;
            mask_n  = '1;
            chip_n  = 1'b1;
          end else if (wdata == CMD_SECT) begin
            st_n   = ST_ERS_WIN;
            mask_n = sector_bit(addr);
            win_n  = '0;
            chip_n = 1'b0;
          end else begin
            st_n = ST_ARRAY;
          end
        end
      end
      ST_AUTOSEL: if (wr_en) st_n = ST_ARRAY;
      ST_PGM_BUSY: if (arr_done) st_n = ST_ARRAY;
      ST_ERS_WIN: begin
        if (wr_en && wdata == CMD_SECT) mask_n = mask_q | sector_bit(addr);
        if (win_last) begin
          st_n    = ST_ERS_RUN;
          start_n = 1'b1;
          op_n    = OP_ERASE;
        end else begin
          win_n = win_q + 1'b1;
        end
      end
      ST_ERS_RUN: begin
        if (arr_done)      st_n = ST_ARRAY;
        else if (susp_req) st_n = ST_ERS_SUSP;
      end
      ST_ERS_SUSP: if (wr_en && wdata == CMD_SECT) st_n = ST_ERS_RUN;
      default: st_n = ST_ARRAY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_ARRAY;
      start_q <= 1'b0;
      op_q    <= OP_PROGRAM;
      addr_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
      win_q   <= '0;
      chip_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      start_q <= start_n;
      op_q    <= op_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
      mask_q  <= mask_n;
      win_q   <= win_n;
      chip_q  <= chip_n;
    end
  end

  assign st          = st_q;
  assign arr_start   = start_q;
  assign arr_op      = op_q;
  assign arr_addr    = addr_q;
  assign arr_wdata   = data_q;
  assign arr_mask    = mask_q;
  assign arr_suspend = (st_q == ST_ERS_SUSP);
  assign rdy         = !is_busy(st_q);

  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |=> !arr_start);
  // R6
  busy_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> !rdy);
  // R6
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done_evt |=> rdy);
  // R11
  done_beats_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done_evt && susp_req) |=> (!arr_suspend && rdy));
  // R10
  suspend_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_suspend |-> (rdy && !arr_start));
  // R5
  erase_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_start && arr_op == OP_ERASE) |-> (arr_mask != '0));
  // R5
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERS_WIN) |-> (win_q < WIN_W'(SE_WIN)));
  // R7
  ident_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AUTOSEL && wr_en) |=> (st == ST_ARRAY));

endmodule

// File: rtl/flash_rd_path.sv
module flash_rd_path
  import flash_cmd_pkg::*;
#(
  parameter int              SECT_W    = 4,
  parameter logic [7:0]      MFR_ID    = 8'h04,
  parameter logic [7:0]      DEV_ID    = 8'h58,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = '0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_sel,
  input  logic                   rd_en,
  input  logic [SECT_W-1:0]      sect_idx,
  input  logic [7:0]             id_off,
  input  dec_state_e             st,
  input  logic                   pgm_bit7,
  input  logic [(1<<SECT_W)-1:0] mask,
  input  logic [7:0]             arr_rdata,
  output logic [7:0]             rdata
);

  function automatic logic [7:0] ident_byte(input logic bs, input logic [7:0] off,
                                            input logic prot);
    logic [7:0] stp;
    stp = bs ? 8'd2 : 8'd1;
    if (off == 8'd0)           return MFR_ID;
    else if (off == stp)       return DEV_ID;
    else if (off == (stp << 1)) return prot ? 8'h01 : 8'h00;
    else                       return 8'h00;
  endfunction

  logic tog6, tog2;
  logic in_sel;
  logic status_rd;

  assign in_sel    = mask[sect_idx];
  assign status_rd = rd_en && is_busy(st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      tog6  <= 1'b0;
      tog2  <= 1'b0;
    end else if (rd_en) begin
      case (st)
        ST_AUTOSEL: rdata <= ident_byte(byte_sel, id_off, PROT_MASK[sect_idx]);
        ST_PGM_BUSY: begin
          rdata <= status_byte(~pgm_bit7, tog6, 1'b0);
          tog6  <= ~tog6;
        end
        ST_ERS_WIN, ST_ERS_RUN: begin
          rdata <= status_byte(1'b0, tog6, tog2);
          tog6  <= ~tog6;
          if (in_sel) tog2 <= ~tog2;
        end
        ST_ERS_SUSP: begin
          if (in_sel) begin
            rdata <= status_byte(1'b1, tog6, tog2);
            tog2  <= ~tog2;
          end else begin
            rdata <= arr_rdata;
          end
        end
        default: rdata <= arr_rdata;
      endcase
    end
  end

  // R8
  busy_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> (tog6 != $past(tog6)));
  // R8
  pgm_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st == ST_PGM_BUSY) |=> (rdata[7] == !$past(pgm_bit7)));
  // R10
  susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ERS_SUSP) |=> $stable(tog6));
  // R9
  unsel_tog2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_sel) |=> $stable(tog2));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         SECT_W    = 4,
  parameter int         SE_WIN    = 8,
  parameter logic [7:0] MFR_ID    = 8'h04,
  parameter logic [7:0] DEV_ID    = 8'h58,
  parameter logic [(1<<SECT_W)-1:0] PROT_MASK = 16'h0002
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_sel,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  input  logic                   rd_en,
  output logic [7:0]             rdata,
  output logic                   rdy,
  output logic                   arr_start,
  output logic                   arr_op,
  output logic [ADDR_W-1:0]      arr_addr,
  output logic [7:0]             arr_wdata,
  output logic [(1<<SECT_W)-1:0] arr_mask,
  output logic                   arr_suspend,
  input  logic                   arr_done,
  input  logic [7:0]             arr_rdata
);

  dec_state_e st;
  arr_op_e    op_e;

  flash_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .SE_WIN(SE_WIN)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_sel    (byte_sel),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .arr_done    (arr_done),
    .st          (st),
    .arr_start   (arr_start),
    .arr_op      (op_e),
    .arr_addr    (arr_addr),
    .arr_wdata   (arr_wdata),
    .arr_mask    (arr_mask),
    .arr_suspend (arr_suspend),
    .rdy         (rdy)
  );

  assign arr_op = op_e;

  flash_rd_path #(.SECT_W(SECT_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
                  .PROT_MASK(PROT_MASK)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_sel  (byte_sel),
    .rd_en     (rd_en),
    .sect_idx  (addr[ADDR_W-1 -: SECT_W]),
    .id_off    (addr[7:0]),
    .st        (st),
    .pgm_bit7  (arr_wdata[7]),
    .mask      (arr_mask),
    .arr_rdata (arr_rdata),
    .rdata     (rdata)
  );

endmodule

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  localparam int SE_WIN = 8;
  localparam int WD_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        rdy, arr_start, arr_op, arr_suspend;
  logic [15:0] arr_addr;
  logic [7:0]  arr_wdata;
  logic [15:0] arr_mask;
  logic        arr_done = 1'b0;
  logic [7:0]  arr_rdata = 8'hFF;

  always #5 clk = ~clk;

  flash_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .byte_sel(byte_sel), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .rdy(rdy), .arr_start(arr_start),
    .arr_op(arr_op), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_mask(arr_mask),
    .arr_suspend(arr_suspend), .arr_done(arr_done), .arr_rdata(arr_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // ---------------- array memory and responder ----------------
  logic [7:0] mem [int];
  int r_lat = 6;
  int r_cnt = 0;
  bit r_busy = 0;
  bit r_op;
  int r_addr;
  logic [7:0] r_data;
  logic [15:0] r_mask;

  function automatic logic [7:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 8'hFF;
  endfunction

  // ---------------- behavioural reference ----------------
  int qa[$];
  int qd[$];
  int m_mode = 0;  // 0 array, 1 ident, 2 program busy, 3 window, 4 erase run, 5 suspended
  bit m_chip = 0;
  logic [15:0] m_mask = '0;
  int m_wcnt = 0;
  logic [7:0] m_pd = '0;
  bit e_start = 0;
  bit e_op = 0;
  int e_addr = 0;
  logic [7:0] e_data = '0;
  logic [7:0] e_rdata = '0;
  string e_rtag = "R6";
  string e_stag = "R3";
  bit t6 = 0;
  bit t2 = 0;

  function automatic int classify();
    int n = qa.size();
    int u1 = byte_sel ? 'hAAAA : 'h5555;
    int u2 = byte_sel ? 'h5555 : 'h2AAA;
    if (!(qa[0] == u1 && qd[0] == 'hAA)) return -1;
    if (n == 1) return 0;
    if (!(qa[1] == u2 && qd[1] == 'h55)) return -1;
    if (n == 2) return 0;
    if (qa[2] != u1) return -1;
    if (qd[2] == 'hA0) return (n == 3) ? 0 : 1;
    if (qd[2] == 'h90) return 2;
    if (qd[2] != 'h80) return -1;
    if (n == 3) return 0;
    if (!(qa[3] == u1 && qd[3] == 'hAA)) return -1;
    if (n == 4) return 0;
    if (!(qa[4] == u2 && qd[4] == 'h55)) return -1;
    if (n == 5) return 0;
    if (qa[5] == u1 && qd[5] == 'h10) return 3;
    if (qd[5] == 'h30) return 4;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_mask = '0; e_start = 0; e_rdata = '0; t6 = 0; t2 = 0;
      qa.delete(); qd.delete();
    end else begin
      int sec;
      int off;
      int stp;
      bit sel;
      e_start = 0;
      sec = int'(addr[15:12]);
      sel = m_mask[sec];
      if (rd_en) begin
        case (m_mode)
          1: begin
            off = int'(addr[7:0]);
            stp = byte_sel ? 2 : 1;
            if (off == 0) e_rdata = 8'h04;
            else if (off == stp) e_rdata = 8'h58;
            else if (off == 2 * stp) e_rdata = (sec == 1) ? 8'h01 : 8'h00;
            else e_rdata = 8'h00;
            e_rtag = "R7";
          end
          2: begin
            e_rdata = {~m_pd[7], t6, 6'b0};
            t6 = ~t6; e_rtag = "R8";
          end
          3, 4: begin
            e_rdata = {1'b0, t6, 3'b0, t2, 2'b0};
            t6 = ~t6;
            if (sel) t2 = ~t2;
            e_rtag = "R9";
          end
          5: begin
            if (sel) begin
              e_rdata = {1'b1, t6, 3'b0, t2, 2'b0};
              t2 = ~t2;
            end else e_rdata = arr_rdata;
            e_rtag = "R10";
          end
          default: begin e_rdata = arr_rdata; e_rtag = "R2"; end
        endcase
      end
      case (m_mode)
        0: if (wr_en) begin
          int k;
          qa.push_back(int'(addr)); qd.push_back(int'(wdata));
          k = classify();
          if (k != 0) begin
            if (k == 1) begin
              m_mode = 2; e_start = 1; e_op = 0; e_addr = qa[3]; e_data = qd[3][7:0];
              m_pd = qd[3][7:0]; e_stag = "R3";
            end else if (k == 2) m_mode = 1;
            else if (k == 3) begin
              m_mode = 4; e_start = 1; e_op = 1; m_mask = '1; m_chip = 1; e_stag = "R4";
            end else if (k == 4) begin
              m_mode = 3; m_mask = '0; m_mask[sec] = 1'b1; m_chip = 0; m_wcnt = 0;
            end
            qa.delete(); qd.delete();
          end
        end
        1: if (wr_en) m_mode = 0;
        2: if (arr_done) m_mode = 0;
        3: begin
          if (wr_en && wdata == 8'h30) m_mask[sec] = 1'b1;
          m_wcnt++;
          if (m_wcnt == SE_WIN) begin
            m_mode = 4; e_start = 1; e_op = 1; e_stag = "R5";
          end
        end
        4: begin
          if (arr_done) m_mode = 0;
          else if (wr_en && wdata == 8'hB0 && !m_chip) m_mode = 5;
        end
        5: if (wr_en && wdata == 8'h30) m_mode = 4;
        default: m_mode = 0;
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare, run the array responder, then drive the next inputs
  task automatic step(input bit w, input logic [15:0] a, input logic [7:0] d, input bit r);
    bit e_rdy;
    @(negedge clk);
    if (rst_n) begin
      e_rdy = !(m_mode == 2 || m_mode == 3 || m_mode == 4);
      chk(rdy === e_rdy, (m_mode == 5) ? "R10" : "R6", "rdy", rdy, e_rdy);
      chk(rdata === e_rdata, e_rtag, "rdata", rdata, e_rdata);
      chk(arr_start === e_start, e_stag, "arr_start", arr_start, e_start);
      chk(arr_suspend === (m_mode == 5), "R10", "arr_suspend", arr_suspend, m_mode == 5);
      if (e_start) begin
        chk(arr_op === e_op, e_stag, "arr_op", arr_op, e_op);
        if (!e_op) begin
          chk(arr_addr === e_addr[15:0], "R3", "arr_addr", arr_addr, e_addr);
          chk(arr_wdata === e_data, "R3", "arr_wdata", arr_wdata, e_data);
        end else begin
          chk(arr_mask === m_mask, e_stag, "arr_mask", arr_mask, m_mask);
        end
      end
    end
    arr_done = 1'b0;
    if (arr_start) begin
      r_busy = 1; r_cnt = r_lat; r_op = arr_op; r_addr = int'(arr_addr);
      r_data = arr_wdata; r_mask = arr_mask;
    end else if (r_busy && !arr_suspend) begin
      r_cnt--;
      if (r_cnt == 0) begin
        arr_done = 1'b1; r_busy = 0;
        if (!r_op) mem[r_addr] = r_data;
        else foreach (mem[k]) if (r_mask[k >> 12]) mem[k] = 8'hFF;
      end
    end
    wr_en = w; addr = a; wdata = d; rd_en = r;
    arr_rdata = mem_rd(int'(a));
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    step(1, a, d, 0);
  endtask
  task automatic rd(input logic [15:0] a);
    step(0, a, 8'h00, 1);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 16'h0, 8'h00, 0);
  endtask
  task automatic unlock();
    wr(byte_sel ? 16'hAAAA : 16'h5555, 8'hAA);
    wr(byte_sel ? 16'h5555 : 16'h2AAA, 8'h55);
  endtask
  task automatic cmd(input logic [7:0] c);
    unlock();
    wr(byte_sel ? 16'hAAAA : 16'h5555, c);
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      step(0, 16'h0, 8'h00, 0);
      if (rdy && !r_busy && !arr_suspend) break;
    end
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    mem[16'h1234] = 8'h5A;
    mem[16'h4010] = 8'h77;
    mem[16'h3004] = 8'h12;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);                        // R6 reset state: rdy high, rdata 0
    rd(16'h1234); idle(1);          // R2 array read

    // R3 program, word mode; R8 status polling
    r_lat = 10;
    cmd(8'hA0); wr(16'h3010, 8'hC3);
    rd(16'h3010); rd(16'h3010); rd(16'h0100);
    wr(16'h5555, 8'hAA);            // R6 ignored while busy
    wait_idle(); rd(16'h3010); idle(1);

    // R1 byte-mode unlock, program bit7 = 0
    byte_sel = 1'b1;
    cmd(8'hA0); wr(16'h2000, 8'h35);
    rd(16'h2000); rd(16'h2000);
    wait_idle(); rd(16'h2000); idle(1);

    // R7 identifier, byte offsets
    cmd(8'h90);
    rd(16'h0000); rd(16'h0002); rd(16'h1004); rd(16'h0004); rd(16'h0003);
    wr(16'h0000, 8'hF0); rd(16'h1234); idle(1);
    byte_sel = 1'b0;

    // R7 identifier, word offsets
    cmd(8'h90);
    rd(16'h0000); rd(16'h0001); rd(16'h1002); rd(16'h2002); rd(16'h0007);
    wr(16'h0000, 8'h00); rd(16'h1234); idle(1);

    // R2 sequence breaks
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h56); rd(16'h1234);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'hF0); rd(16'h1234);
    unlock(); wr(16'h1111, 8'hA0); wr(16'h3004, 8'h00); rd(16'h3004);
    wr(16'h5555, 8'hF0); idle(2);

    // R4 chip erase; R9 polling; B0 ignored during chip erase (R10)
    r_lat = 20;
    cmd(8'h80); unlock(); wr(16'h5555, 8'h10);
    rd(16'h3010); rd(16'h9000); wr(16'h5555, 8'hB0); rd(16'h3010);
    wait_idle(); rd(16'h3010); rd(16'h1234); idle(1);

    // R5 sector erase with window, R9 selective bit2, R10 suspend and resume
    mem[16'h4010] = 8'h77; mem[16'h3004] = 8'h12; mem[16'h7008] = 8'h44;
    r_lat = 15;
    cmd(8'h80); unlock(); wr(16'h3000, 8'h30);
    wr(16'h0000, 8'h30);            // sector 0 on the first window edge
    idle(SE_WIN - 2);
    wr(16'h7000, 8'h30);            // sector 7 on the last window edge
    rd(16'h3004); rd(16'h4010); rd(16'h7008); rd(16'h4010);
    wr(16'h0000, 8'hB0);
    idle(2);
    rd(16'h4010); rd(16'h3004); rd(16'h3004); rd(16'h4010);
    wr(16'h0000, 8'h30);            // resume
    rd(16'h3004);
    wait_idle(); rd(16'h3004); rd(16'h4010); rd(16'h7008); idle(1);

    // R11 done and suspend in the same cycle
    r_lat = 5;
    cmd(8'h80); unlock(); wr(16'h6000, 8'h30);
    for (int i = 0; i < 200; i++) begin
      if (r_busy && r_cnt == 1) break;
      step(0, 16'h0, 8'h00, 0);
    end
    wr(16'h0000, 8'hB0);
    idle(3);
    rd(16'h6000); idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule